// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt sources and turns input activity into interrupt offers for a downstream presentation unit. Each source is fixed at build time as either a level source or a message source, and each keeps a target server and a priority. The all-ones priority means masked. Offers leave through a registered valid/ready port that carries the target server, the global source number and the priority. The global number is the local index plus a fixed base.

The presentation unit reports back through one event port. It can send a reject, which says an offer was displaced, or an end-of-interrupt. It also has a separate resend request, which starts a scan that visits one source per clock. The two source types retry differently. A message source that fires while masked, or that is rejected, is remembered and replayed later. A level source is offered again only when it is asserted, unmasked and not already marked as sent.

Top module: `intsrc_bank`

## Requirements
- R1: After reset every source is masked (priority all ones), no offer is valid and `resend_busy` is low. A message pulse on an unconfigured source produces no offer.
- R2: A pulse on an unmasked message source produces exactly one offer carrying its server, the number BASE+index and its priority.
- R3: A pulse on a masked message source produces no offer but is remembered. A later configuration write that unmasks the source produces exactly one offer with the new server and priority.
- R4: A rising level input on an unmasked level source that is not marked sent produces one offer and marks it sent. Further rising edges while it is marked sent produce nothing.
- R5: An end-of-interrupt (`evt_kind` = 2'b10) clears the sent mark of a level source and does not offer by itself; the next rising edge offers again. An end-of-interrupt on a message source has no effect.
- R6: A reject (`evt_kind` = 2'b01) on a message source marks it rejected. The next resend scan replays it once, and a further scan replays nothing.
- R7: A reject on a level source clears its sent mark without offering. A resend scan then offers it again if its input is still asserted.
- R8: A configuration write that unmasks a level source whose input is already asserted and not sent produces an offer. A write to an unasserted level source produces none.
- R9: Event and configuration numbers outside BASE to BASE+NUM_SRC-1 are ignored.
- R10: While `offer_valid` is high and `offer_ready` is low, the offer fields stay constant. When several sources wait, the lowest index is offered first, and none is lost.
- R11: A resend request taken while idle raises `resend_busy` for exactly NUM_SRC cycles, starting on the next cycle. Requests that arrive while busy are ignored.
- R12: Masking a source whose offer waits inside the bank withdraws the offer. A message source turns it into a remembered pending, and a level source has its sent mark cleared. An offer never carries the mask priority.
- R13: When a configuration write and a message pulse hit the same source in the same cycle, the pulse is judged against the newly written priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Per-source input: a one-cycle pulse for message sources, a level for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global number of the source to configure |
| cfg_server | input | SRV_W | Target server to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks the source) |
| evt_valid | input | 1 | Returned event strobe |
| evt_kind | input | 2 | 2'b01 reject, 2'b10 end-of-interrupt, others ignored |
| evt_num | input | NUM_W | Global number the event refers to |
| resend_req | input | 1 | Start a resend scan |
| resend_busy | output | 1 | Resend scan in progress |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Downstream takes the offer |
| offer_server | output | SRV_W | Server of the offer |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |

## Verification
Two kinds of event can land on the same source in one clock. One case is a configuration write together with a message pulse. The other is a mask write that arrives while that source's offer is still waiting behind a stalled output. The bench causes the first by driving the write strobe and the pulse in the same cycle on a masked source. It passes only if exactly one offer comes out, carrying the new priority. It causes the second by holding `offer_ready` low, firing a second source and masking it before releasing ready. It passes only if the first offer is delivered, the withdrawn one never appears, and a later unmask delivers it once.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
   // Encoding of events returned by the presentation unit
   typedef enum logic [1:0] {
      EVK_NONE   = 2'b00,
      EVK_REJECT = 2'b01,
      EVK_EOI    = 2'b10,
      EVK_RSVD   = 2'b11
   } evt_kind_e;
endpackage

// File: rtl/intsrc_lvl_slot.sv
module intsrc_lvl_slot #(
   parameter int SRV_W  = 8,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_in,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              scan_hit,
   input  logic              taken,
   output logic              want,
   output logic [SRV_W-1:0]  server,
   output logic [PRIO_W-1:0] prio
);
   logic [SRV_W-1:0]  srv_q, srv_d;
   logic [PRIO_W-1:0] pri_q, pri_d;
   logic as_q, as_d, sent_q, sent_d, want_q, want_d;

   always_comb begin
      srv_d  = srv_q;
      pri_d  = pri_q;
      as_d   = lvl_in;
      sent_d = sent_q;
      want_d = want_q;
      if (taken) want_d = 1'b0;
      if (rej_hit || eoi_hit) sent_d = 1'b0;
      if (cfg_hit) begin
         srv_d = cfg_server;
         pri_d = cfg_prio;
         if ((&cfg_prio) && want_d) begin
            want_d = 1'b0;
            sent_d = 1'b0;
         end else if (!(&pri_d) && as_q && !sent_d) begin
            sent_d = 1'b1;
            want_d = 1'b1;
         end
      end
      if (lvl_in && !as_q && !(&pri_d) && !sent_d) begin
         sent_d = 1'b1;
         want_d = 1'b1;
      end
      if (scan_hit && as_d && !(&pri_d) && !sent_d) begin
         sent_d = 1'b1;
         want_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q  <= '0;
         pri_q  <= '1;
         as_q   <= 1'b0;
         sent_q <= 1'b0;
         want_q <= 1'b0;
      end else begin
         srv_q  <= srv_d;
         pri_q  <= pri_d;
         as_q   <= as_d;
         sent_q <= sent_d;
         want_q <= want_d;
      end
   end

   assign want   = want_q;
   assign server = srv_q;
   assign prio   = pri_q;

   // R4
   sent_with_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sent_q) |-> want_q);
   // R12
   no_masked_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
      want_q |-> !(&pri_q));
endmodule

// File: rtl/intsrc_msg_slot.sv
module intsrc_msg_slot #(
   parameter int SRV_W  = 8,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic              rej_hit,
   input  logic              scan_hit,
   input  logic              taken,
   output logic              want,
   output logic [SRV_W-1:0]  server,
   output logic [PRIO_W-1:0] prio
);
   logic [SRV_W-1:0]  srv_q, srv_d;
   logic [PRIO_W-1:0] pri_q, pri_d;
   logic mp_q, mp_d, rj_q, rj_d, want_q, want_d;

   always_comb begin
      srv_d  = srv_q;
      pri_d  = pri_q;
      mp_d   = mp_q;
      rj_d   = rj_q;
      want_d = want_q;
      if (taken) want_d = 1'b0;
      if (rej_hit) rj_d = 1'b1;
      if (cfg_hit) begin
         srv_d = cfg_server;
         pri_d = cfg_prio;
         if ((&cfg_prio) && want_d) begin
            want_d = 1'b0;
            mp_d   = 1'b1;
         end else if (mp_d && !(&cfg_prio)) begin
            mp_d   = 1'b0;
            want_d = 1'b1;
         end
      end
      if (fire) begin
         if (&pri_d) mp_d = 1'b1;
         else        want_d = 1'b1;
      end
      if (scan_hit && rj_d) begin
         rj_d = 1'b0;
         if (!(&pri_d)) want_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q  <= '0;
         pri_q  <= '1;
         mp_q   <= 1'b0;
         rj_q   <= 1'b0;
         want_q <= 1'b0;
      end else begin
         srv_q  <= srv_d;
         pri_q  <= pri_d;
         mp_q   <= mp_d;
         rj_q   <= rj_d;
         want_q <= want_d;
      end
   end

   assign want   = want_q;
   assign server = srv_q;
   assign prio   = pri_q;

   // R3
   pend_only_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mp_q |-> (&pri_q) && !want_q);
endmodule

// File: rtl/intsrc_pick.sv
module intsrc_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/intsrc_bank.sv
module intsrc_bank #(
   parameter int                 NUM_SRC    = 8,
   parameter int                 SRV_W      = 8,
   parameter int                 PRIO_W     = 8,
   parameter int                 NUM_W      = 16,
   parameter int                 BASE       = 4096,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               cfg_we,
   input  logic [NUM_W-1:0]   cfg_num,
   input  logic [SRV_W-1:0]   cfg_server,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic               evt_valid,
   input  logic [1:0]         evt_kind,
   input  logic [NUM_W-1:0]   evt_num,
   input  logic               resend_req,
   output logic               resend_busy,
   output logic               offer_valid,
   input  logic               offer_ready,
   output logic [SRV_W-1:0]   offer_server,
   output logic [NUM_W-1:0]   offer_num,
   output logic [PRIO_W-1:0]  offer_prio
);
   import intsrc_pkg::*;

   localparam int               IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [NUM_W-1:0] BASE_V  = NUM_W'(BASE);
   localparam logic [NUM_W-1:0] COUNT_V = NUM_W'(NUM_SRC);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_SRC - 1);

   if (NUM_SRC < 1) begin : g_bad_count
      $error("intsrc_bank: NUM_SRC must be at least 1");
   end
   if (PRIO_W < 2 || SRV_W < 1) begin : g_bad_width
      $error("intsrc_bank: PRIO_W must be >= 2 and SRV_W >= 1");
   end
   if (longint'(BASE) + longint'(NUM_SRC) > (longint'(1) << NUM_W)) begin : g_bad_base
      $error("intsrc_bank: BASE + NUM_SRC does not fit in NUM_W bits");
   end

   // Number decode: global number minus base gives the local index
   logic [NUM_W-1:0] evt_off, cfg_off;
   logic             evt_ok, cfg_ok;
   logic             is_rej, is_eoi;
   assign evt_off = evt_num - BASE_V;
   assign cfg_off = cfg_num - BASE_V;
   assign evt_ok  = evt_valid && (evt_num >= BASE_V) && (evt_off < COUNT_V);
   assign cfg_ok  = cfg_we && (cfg_num >= BASE_V) && (cfg_off < COUNT_V);
   assign is_rej  = evt_kind == EVK_REJECT;
   assign is_eoi  = evt_kind == EVK_EOI;

   // Resend scan, one source per clock
   logic             busy_q;
   logic [IDX_W-1:0] scan_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         scan_q <= '0;
      end else if (busy_q) begin
         if (scan_q == LAST) busy_q <= 1'b0;
         else                scan_q <= scan_q + 1'b1;
      end else if (resend_req) begin
         busy_q <= 1'b1;
         scan_q <= '0;
      end
   end
   assign resend_busy = busy_q;

   // Per-source state, variant chosen by type mask
   logic [NUM_SRC-1:0] want, taken;
   logic [SRV_W-1:0]   srv_a [NUM_SRC];
   logic [PRIO_W-1:0]  pri_a [NUM_SRC];
   logic               pick_any, load;
   logic [IDX_W-1:0]   pick_idx;

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      logic cfg_hit, rej_hit, ev_hit, scan_hit;
      assign ev_hit   = evt_ok && (evt_off[IDX_W-1:0] == IDX_W'(gi));
      assign rej_hit  = ev_hit && is_rej;
      assign cfg_hit  = cfg_ok && (cfg_off[IDX_W-1:0] == IDX_W'(gi));
      assign scan_hit = busy_q && (scan_q == IDX_W'(gi));
      assign taken[gi] = load && (pick_idx == IDX_W'(gi));
      if (LEVEL_MASK[gi]) begin : g_lvl
         intsrc_lvl_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .lvl_in(src_in[gi]),
            .cfg_hit(cfg_hit), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
            .rej_hit(rej_hit), .eoi_hit(ev_hit && is_eoi),
            .scan_hit(scan_hit), .taken(taken[gi]),
            .want(want[gi]), .server(srv_a[gi]), .prio(pri_a[gi]));
      end else begin : g_msg
         intsrc_msg_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .fire(src_in[gi]),
            .cfg_hit(cfg_hit), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
            .rej_hit(rej_hit), .scan_hit(scan_hit), .taken(taken[gi]),
            .want(want[gi]), .server(srv_a[gi]), .prio(pri_a[gi]));
      end
   end

   intsrc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req(want), .any(pick_any), .idx(pick_idx));

   // Registered offer stage
   assign load = pick_any && (!offer_valid || offer_ready);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offer_valid  <= 1'b0;
         offer_server <= '0;
         offer_num    <= '0;
         offer_prio   <= '0;
      end else if (load) begin
         offer_valid  <= 1'b1;
         offer_server <= srv_a[pick_idx];
         offer_num    <= BASE_V + NUM_W'(pick_idx);
         offer_prio   <= pri_a[pick_idx];
      end else if (offer_ready) begin
         offer_valid  <= 1'b0;
      end
   end

   // R10
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
         && $stable(offer_server) && $stable(offer_prio));
   // R12
   offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid |-> !(&offer_prio));
   // R2
   offer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid |-> (offer_num >= BASE_V) && (offer_num - BASE_V < COUNT_V));
   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resend_busy) |-> $past(resend_req));
   // R11
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resend_busy) |-> $past(scan_q) == LAST);
endmodule

// File: tb/intsrc_bank_bench.sv
`timescale 1ns/1ps
module intsrc_bank_bench;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src_in = '0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_num = '0;
   logic [7:0]  cfg_server = '0;
   logic [7:0]  cfg_prio = '0;
   logic        evt_valid = 1'b0;
   logic [1:0]  evt_kind = '0;
   logic [15:0] evt_num = '0;
   logic        resend_req = 1'b0;
   logic        offer_ready = 1'b1;
   logic        resend_busy, offer_valid;
   logic [7:0]  offer_server, offer_prio;
   logic [15:0] offer_num;

   intsrc_bank u_intsrc_bank (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .cfg_we(cfg_we), .cfg_num(cfg_num), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
      .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_num(evt_num),
      .resend_req(resend_req), .resend_busy(resend_busy),
      .offer_valid(offer_valid), .offer_ready(offer_ready),
      .offer_server(offer_server), .offer_num(offer_num), .offer_prio(offer_prio));

   always #2.5 clk = ~clk;

   typedef struct {
      logic [7:0]  srv;
      logic [15:0] num;
      logic [7:0]  prio;
      string       tag;
   } item_t;

   item_t exp_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   int    busy_cnt = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   // Monitor: compare each handshake against the scoreboard
   always @(negedge clk) begin
      if (rst_n && resend_busy) busy_cnt++;
      if (rst_n && offer_valid && offer_ready) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL %s: unexpected offer srv=%0d num=%0d prio=%0d, expected none",
                     cur_tag, offer_server, offer_num, offer_prio);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            if (offer_server !== it.srv || offer_num !== it.num || offer_prio !== it.prio) begin
               n_bad++;
               $display("FAIL %s: offer srv=%0d num=%0d prio=%0d, expected srv=%0d num=%0d prio=%0d",
                        it.tag, offer_server, offer_num, offer_prio, it.srv, it.num, it.prio);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic expect_offer(input logic [7:0] s, input logic [15:0] num,
                               input logic [7:0] p);
      item_t it;
      it.srv = s; it.num = num; it.prio = p; it.tag = cur_tag;
      exp_q.push_back(it);
   endtask

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: %s actual=%0d expected=%0d", cur_tag, what, act, exp);
      end
   endtask

   task automatic settle(input int n);
      tick(n);
      check(exp_q.size() == 0, "offers still outstanding", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic cfg(input int idx, input logic [7:0] s, input logic [7:0] p);
      cfg_we = 1'b1; cfg_num = 16'(4096 + idx); cfg_server = s; cfg_prio = p;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic fire(input int idx);
      src_in[idx] = 1'b1;
      step();
      src_in[idx] = 1'b0;
   endtask

   task automatic evt(input logic [1:0] k, input int num);
      evt_valid = 1'b1; evt_kind = k; evt_num = 16'(num);
      step();
      evt_valid = 1'b0;
   endtask

   task automatic resend();
      resend_req = 1'b1;
      step();
      resend_req = 1'b0;
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      step();
      @(negedge clk);
      cur_tag = "R1";
      check(offer_valid == 1'b0, "offer_valid after reset", offer_valid, 0);
      check(resend_busy == 1'b0, "resend_busy after reset", resend_busy, 0);
      step();
      fire(0);                         // R1: masked by reset
      settle(6);

      cur_tag = "R3";                  // remembered pulse replayed on unmask
      expect_offer(8'd3, 16'd4096, 8'd5);
      cfg(0, 8'd3, 8'd5);
      settle(6);

      cur_tag = "R2";
      cfg(1, 8'd2, 8'd7);
      expect_offer(8'd2, 16'd4097, 8'd7);
      fire(1);
      settle(6);
      expect_offer(8'd2, 16'd4097, 8'd7);
      fire(1);
      settle(6);

      cur_tag = "R8";                  // unasserted level: no offer on cfg
      cfg(4, 8'd1, 8'd4);
      settle(6);

      cur_tag = "R4";
      expect_offer(8'd1, 16'd4100, 8'd4);
      src_in[4] = 1'b1;
      settle(6);
      src_in[4] = 1'b0;
      tick(2);
      src_in[4] = 1'b1;                // still marked sent
      settle(6);

      cur_tag = "R5";
      evt(2'b10, 4100);                // EOI alone offers nothing
      settle(6);
      src_in[4] = 1'b0;
      tick(2);
      expect_offer(8'd1, 16'd4100, 8'd4);
      src_in[4] = 1'b1;
      settle(6);
      evt(2'b10, 4096);                // EOI on message source: no effect
      resend();
      settle(14);

      cur_tag = "R6";
      evt(2'b01, 4097);
      settle(4);
      expect_offer(8'd2, 16'd4097, 8'd7);
      resend();
      settle(14);
      resend();
      settle(14);

      cur_tag = "R7";                  // src4 sent and still asserted
      evt(2'b01, 4100);
      settle(4);
      expect_offer(8'd1, 16'd4100, 8'd4);
      resend();
      settle(14);

      cur_tag = "R8";
      src_in[5] = 1'b1;                // masked level: nothing
      settle(6);
      expect_offer(8'd6, 16'd4101, 8'd2);
      cfg(5, 8'd6, 8'd2);
      settle(6);

      cur_tag = "R9";
      evt(2'b01, 4104);                // would alias to source 0
      cfg(4096 + 8 - 4096 + 8, 8'd1, 8'd1);
      resend();
      settle(14);

      cur_tag = "R10";
      cfg(2, 8'd5, 8'd3);
      offer_ready = 1'b0;
      expect_offer(8'd3, 16'd4096, 8'd5);
      expect_offer(8'd2, 16'd4097, 8'd7);
      expect_offer(8'd5, 16'd4098, 8'd3);
      src_in[2:0] = 3'b111;
      step();
      src_in[2:0] = 3'b000;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check(offer_valid === 1'b1, "held offer_valid", offer_valid, 1);
            check(offer_num === 16'd4096, "held offer_num", offer_num, 4096);
         end
      end
      step();
      offer_ready = 1'b1;
      settle(8);

      cur_tag = "R12";
      offer_ready = 1'b0;
      expect_offer(8'd3, 16'd4096, 8'd5);
      fire(0);
      tick(2);
      fire(1);                          // waits inside the bank
      tick(1);
      cfg(1, 8'd2, 8'hFF);             // withdraw
      offer_ready = 1'b1;
      settle(8);
      expect_offer(8'd2, 16'd4097, 8'd9);
      cfg(1, 8'd2, 8'd9);
      settle(8);

      cur_tag = "R11";
      busy_cnt = 0;
      resend();
      tick(2);
      resend();                         // ignored while busy
      settle(14);
      check(busy_cnt == N, "resend_busy cycles", busy_cnt, N);

      cur_tag = "R13";
      expect_offer(8'd4, 16'd4099, 8'd1);
      cfg_we = 1'b1; cfg_num = 16'd4099; cfg_server = 8'd4; cfg_prio = 8'd1;
      src_in[3] = 1'b1;
      step();
      cfg_we = 1'b0;
      src_in[3] = 1'b0;
      settle(8);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL %s: watchdog expired actual=running expected=finished", cur_tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule